// File: doc/BRIEF.md
# Suspend and Wake-Up Sequencer

This block takes a small controller-style system into a low-power suspend state and brings it back out. A configuration write carrying a suspend request and a run permission moves the block out of normal operation. It then gates the core clock, the internal oscillator, the free-running timer clock and the watchdog clock. While suspended it watches a fixed set of wake sources. When a valid wake event arrives, it restarts clocking along one of two paths. On the internal-oscillator path it waits a short start-up interval and then a fixed settle delay. On the external-oscillator path it enables the oscillator, waits for the oscillator-stable flag, and then counts a selectable short or long settle delay. Only after that delay does it release the core.

On release, the block raises an interrupt-hold signal for exactly one cycle. This lets the core execute the instruction that follows the suspend-entering write before it services any pending interrupt. The oscillator itself is modelled only as a stable flag, and every delay is counted in cycles of the always-on reference clock that runs the block.

The states are RUN, SUSPEND, CLK_START, OSC_WAIT, DELAY and RELEASE. The transitions are:
- enter (RUN to SUSPEND, on a configuration write with the suspend bit set);
- wake_int (SUSPEND to CLK_START);
- wake_ext (SUSPEND to OSC_WAIT);
- started (CLK_START to DELAY);
- stable (OSC_WAIT to DELAY);
- expired (DELAY to RELEASE);
- resume (RELEASE to RUN).

Top module: `susp_wake_seq`

## Requirements
- R1: After reset the block is in RUN: core_clk_en, int_clk_en, tmr_clk_en, wdt_clk_en and core_run are 1, irq_hold is 0, and ext_osc_en follows ext_clk_sel.
- R2: A cycle with cfg_wr=1 and cfg_suspend=1 in RUN moves the block to SUSPEND at the next edge, where every clock enable, ext_osc_en and core_run are 0. A write with cfg_suspend=0 is ignored.
- R3: In SUSPEND, exactly four conditions count as a wake: gpio_pend&gpio_en, wkt_pend&wkt_en, spi_pend&spi_en, and dminus_in low. dminus_in is seen through a two-flop synchronizer, so it acts two cycles later than the other sources. A pending source whose enable is 0 does not wake the block.
- R4: A wake condition already present on the entering write does not prevent suspend: the block spends at least one cycle in SUSPEND and then runs the full resume delay.
- R5: If cfg_run was 0 on the entering write, the block stays in SUSPEND whatever the wake inputs do, until reset.
- R6: Internal path (ext_clk_sel=0 at entry): CLK_START lasts START_TICKS cycles with all clocks off. DELAY then lasts INT_DELAY_TICKS cycles with only int_clk_en=1.
- R7: External path (ext_clk_sel=1 at entry): from the wake until release, ext_osc_en=1 and int_clk_en=0. The block stays in OSC_WAIT until osc_stable=1.
- R8: On the external path, DELAY lasts EXT_LONG_TICKS cycles when long_delay_sel was 1 at entry, and EXT_SHORT_TICKS cycles otherwise.
- R9: RELEASE lasts exactly one cycle, with core_clk_en=1, core_run=1 and irq_hold=1. The block then enters RUN with irq_hold=0.
- R10: tmr_clk_en and wdt_clk_en are 1 only in RUN.
- R11: The clock path and delay length are captured on the entering write. Changing ext_clk_sel or long_delay_sel during suspend does not alter them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on reference clock; one cycle is one delay tick |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_suspend | input | 1 | Suspend request bit of the write |
| cfg_run | input | 1 | Run permission bit of the write |
| ext_clk_sel | input | 1 | 1 selects the external-oscillator resume path |
| long_delay_sel | input | 1 | 1 selects the long external settle delay |
| gpio_pend | input | 1 | GPIO interrupt pending |
| gpio_en | input | 1 | GPIO interrupt enable |
| wkt_pend | input | 1 | Wake-up timer interrupt pending |
| wkt_en | input | 1 | Wake-up timer interrupt enable |
| spi_pend | input | 1 | SPI slave interrupt pending |
| spi_en | input | 1 | SPI slave interrupt enable |
| dminus_in | input | 1 | Raw USB D- line level; low is a wake |
| osc_stable | input | 1 | External oscillator has stabilised |
| core_clk_en | output | 1 | Core clock enable |
| int_clk_en | output | 1 | Internal oscillator enable |
| ext_osc_en | output | 1 | External oscillator enable |
| tmr_clk_en | output | 1 | Free-running timer clock enable |
| wdt_clk_en | output | 1 | Watchdog timer clock enable |
| core_run | output | 1 | Core execution released |
| irq_hold | output | 1 | Hold off interrupt service for the first instruction after resume |

## Verification
The bench measures the wake-to-release latency on each path. A counter that is off by one, or a path that skips CLK_START, would release the core one or more cycles early or late. It wakes the block through D- and checks the two-cycle synchronizer lag; a design that evaluated the raw line would release two cycles early. It also asserts pending sources with their enables clear, which a design that ignored the enables would take as a wake. The bench holds a wake condition across the suspend write and expects a suspended cycle first; a design that skipped it would never gate the clocks. It toggles the mode inputs during suspend and expects the captured path to hold. Finally it suspends with the run bit clear and expects the block never to resume, where a faulty design would wake.

// File: rtl/susp_pkg.sv
package susp_pkg;

    typedef enum logic [2:0] {
        ST_RUN       = 3'd0,
        ST_SUSPEND   = 3'd1,
        ST_CLK_START = 3'd2,
        ST_OSC_WAIT  = 3'd3,
        ST_DELAY     = 3'd4,
        ST_RELEASE   = 3'd5
    } susp_state_e;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/susp_sync2.sv
module susp_sync2 #(
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic stage1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= RST_VAL;
            q      <= RST_VAL;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/susp_wake_detect.sv
module susp_wake_detect #(
    parameter int N_SRC = 3
) (
    input  logic [N_SRC-1:0] src_pend,
    input  logic [N_SRC-1:0] src_en,
    input  logic             dminus_sync,
    output logic             wake
);
    logic [N_SRC-1:0] armed;

    for (genvar i = 0; i < N_SRC; i++) begin : g_src
        assign armed[i] = src_pend[i] & src_en[i];
    end

    assign wake = (|armed) | ~dminus_sync;
endmodule

// File: rtl/susp_tick_counter.sv
module susp_tick_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);

    // Once expired, the count stays at zero until reloaded (R8 window integrity)
    assert_cnt_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !load) |=> done);
endmodule

// File: rtl/susp_wake_seq.sv
module susp_wake_seq
    import susp_pkg::*;
#(
    parameter int START_TICKS     = 2,
    parameter int INT_DELAY_TICKS = 8,
    parameter int EXT_SHORT_TICKS = 128,
    parameter int EXT_LONG_TICKS  = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_wr,
    input  logic cfg_suspend,
    input  logic cfg_run,
    input  logic ext_clk_sel,
    input  logic long_delay_sel,
    input  logic gpio_pend,
    input  logic gpio_en,
    input  logic wkt_pend,
    input  logic wkt_en,
    input  logic spi_pend,
    input  logic spi_en,
    input  logic dminus_in,
    input  logic osc_stable,
    output logic core_clk_en,
    output logic int_clk_en,
    output logic ext_osc_en,
    output logic tmr_clk_en,
    output logic wdt_clk_en,
    output logic core_run,
    output logic irq_hold
);
    localparam int MAX_TICKS = max2(max2(START_TICKS, INT_DELAY_TICKS),
                                    max2(EXT_SHORT_TICKS, EXT_LONG_TICKS));
    localparam int CW = $clog2(MAX_TICKS + 1);
    localparam logic [CW-1:0] LD_START = CW'(START_TICKS - 1);
    localparam logic [CW-1:0] LD_INT   = CW'(INT_DELAY_TICKS - 1);
    localparam logic [CW-1:0] LD_SHORT = CW'(EXT_SHORT_TICKS - 1);
    localparam logic [CW-1:0] LD_LONG  = CW'(EXT_LONG_TICKS - 1);

    susp_state_e state, state_nx;
    logic        run_q, ext_q, long_q;
    logic        dminus_sync, wake, tick_done, tick_load;
    logic [CW-1:0] tick_val;
    logic        enter_req;

    assign enter_req = (state == ST_RUN) && cfg_wr && cfg_suspend;

    susp_sync2 #(.RST_VAL(1'b1)) u_dm_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (dminus_in),
        .q     (dminus_sync)
    );

    susp_wake_detect #(.N_SRC(3)) u_wake (
        .src_pend    ({spi_pend, wkt_pend, gpio_pend}),
        .src_en      ({spi_en, wkt_en, gpio_en}),
        .dminus_sync (dminus_sync),
        .wake        (wake)
    );

    susp_tick_counter #(.W(CW)) u_ticks (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tick_load),
        .load_val (tick_val),
        .done     (tick_done)
    );

    // Mode capture on the entering write
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q  <= 1'b0;
            ext_q  <= 1'b0;
            long_q <= 1'b0;
        end else if (enter_req) begin
            run_q  <= cfg_run;
            ext_q  <= ext_clk_sel;
            long_q <= long_delay_sel;
        end
    end

    // Transitions and delay loads
    always_comb begin
        state_nx  = state;
        tick_load = 1'b0;
        tick_val  = '0;
        unique case (state)
            ST_RUN: begin
                if (enter_req) state_nx = ST_SUSPEND;
            end
            ST_SUSPEND: begin
                if (run_q && wake) begin
                    if (ext_q) begin
                        state_nx = ST_OSC_WAIT;
                    end else begin
                        state_nx  = ST_CLK_START;
                        tick_load = 1'b1;
                        tick_val  = LD_START;
                    end
                end
            end
            ST_CLK_START: begin
                if (tick_done) begin
                    state_nx  = ST_DELAY;
                    tick_load = 1'b1;
                    tick_val  = LD_INT;
                end
            end
            ST_OSC_WAIT: begin
                if (osc_stable) begin
                    state_nx  = ST_DELAY;
                    tick_load = 1'b1;
                    tick_val  = long_q ? LD_LONG : LD_SHORT;
                end
            end
            ST_DELAY: begin
                if (tick_done) state_nx = ST_RELEASE;
            end
            ST_RELEASE: state_nx = ST_RUN;
            default:    state_nx = ST_RUN;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= state_nx;
    end

    // Outputs
    always_comb begin
        core_clk_en = 1'b0;
        int_clk_en  = 1'b0;
        ext_osc_en  = 1'b0;
        tmr_clk_en  = 1'b0;
        wdt_clk_en  = 1'b0;
        core_run    = 1'b0;
        irq_hold    = 1'b0;
        unique case (state)
            ST_RUN: begin
                core_clk_en = 1'b1;
                int_clk_en  = 1'b1;
                ext_osc_en  = ext_clk_sel;
                tmr_clk_en  = 1'b1;
                wdt_clk_en  = 1'b1;
                core_run    = 1'b1;
            end
            ST_SUSPEND, ST_CLK_START: ;
            ST_OSC_WAIT: ext_osc_en = 1'b1;
            ST_DELAY: begin
                int_clk_en = ~ext_q;
                ext_osc_en = ext_q;
            end
            ST_RELEASE: begin
                core_clk_en = 1'b1;
                int_clk_en  = ~ext_q;
                ext_osc_en  = ext_q;
                core_run    = 1'b1;
                irq_hold    = 1'b1;
            end
            default: ;
        endcase
    end

    assert_enter_gates_R2: assert property (@(posedge clk) disable iff (!rst_n)
        enter_req |=> (!core_clk_en && !core_run && !tmr_clk_en));

    assert_wake_leaves_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SUSPEND && run_q && wake) |=> (state != ST_SUSPEND));

    assert_norun_stays_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SUSPEND && !run_q) |=> (state == ST_SUSPEND));

    assert_osc_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OSC_WAIT && !osc_stable) |=> (ext_osc_en && !core_run));

    assert_hold_one_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_hold |=> (!irq_hold && core_run && tmr_clk_en));

    assert_timers_follow_core_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tmr_clk_en) |-> $past(irq_hold));
endmodule

// File: tb/susp_wake_seq_bench.sv
module susp_wake_seq_bench;
    localparam int CLK_PERIOD = 10;
    localparam int T_START = 2;
    localparam int T_INT   = 8;
    localparam int T_SHORT = 128;
    localparam int T_LONG  = 4096;
    localparam int WD_LIMIT = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_wr = 0, cfg_suspend = 0, cfg_run = 0, ext_clk_sel = 0, long_delay_sel = 0;
    logic gpio_pend = 0, gpio_en = 0, wkt_pend = 0, wkt_en = 0, spi_pend = 0, spi_en = 0;
    logic dminus_in = 1, osc_stable = 0;
    logic core_clk_en, int_clk_en, ext_osc_en, tmr_clk_en, wdt_clk_en, core_run, irq_hold;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    bit done_flag = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    susp_wake_seq #(
        .START_TICKS(T_START), .INT_DELAY_TICKS(T_INT),
        .EXT_SHORT_TICKS(T_SHORT), .EXT_LONG_TICKS(T_LONG)
    ) u_susp_wake_seq (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_suspend(cfg_suspend),
        .cfg_run(cfg_run), .ext_clk_sel(ext_clk_sel), .long_delay_sel(long_delay_sel),
        .gpio_pend(gpio_pend), .gpio_en(gpio_en), .wkt_pend(wkt_pend), .wkt_en(wkt_en),
        .spi_pend(spi_pend), .spi_en(spi_en), .dminus_in(dminus_in), .osc_stable(osc_stable),
        .core_clk_en(core_clk_en), .int_clk_en(int_clk_en), .ext_osc_en(ext_osc_en),
        .tmr_clk_en(tmr_clk_en), .wdt_clk_en(wdt_clk_en), .core_run(core_run), .irq_hold(irq_hold)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    // Behavioural reference: phase 0 run,1 asleep,2 start,3 osc,4 settle,5 release
    int  m_ph = 0;
    int  m_left = 0;
    bit  m_run = 0, m_ext = 0, m_long = 0;
    bit  hist[$] = '{1'b1, 1'b1};

    always @(posedge clk) begin
        cycles++;
        if (cycles >= WD_LIMIT) begin
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected<%0d", cycles, WD_LIMIT);
            finish_run();
        end
        if (!rst_n) begin
            m_ph = 0; m_left = 0; m_run = 0; m_ext = 0; m_long = 0;
            hist = '{1'b1, 1'b1};
        end else begin
            bit wk;
            wk = (gpio_pend && gpio_en) || (wkt_pend && wkt_en) ||
                 (spi_pend && spi_en) || !hist[0];
            case (m_ph)
                0: if (cfg_wr && cfg_suspend) begin
                       m_ph = 1; m_run = cfg_run; m_ext = ext_clk_sel; m_long = long_delay_sel;
                   end
                1: if (m_run && wk) begin
                       if (m_ext) m_ph = 3;
                       else begin m_ph = 2; m_left = T_START; end
                   end
                2: begin m_left--; if (m_left == 0) begin m_ph = 4; m_left = T_INT; end end
                3: if (osc_stable) begin m_ph = 4; m_left = m_long ? T_LONG : T_SHORT; end
                4: begin m_left--; if (m_left == 0) m_ph = 5; end
                default: m_ph = 0;
            endcase
            hist.push_back(dminus_in);
            void'(hist.pop_front());
        end
    end

    // Per-cycle comparison against the reference
    always @(negedge clk) begin
        #1;
        if (rst_n) begin
            logic [6:0] exp_v, act_v;
            string tag;
            case (m_ph)
                0: begin exp_v = {1'b1, 1'b1, ext_clk_sel, 1'b1, 1'b1, 1'b1, 1'b0}; tag = "R1_R10_run"; end
                1: begin exp_v = 7'b0; tag = "R2_suspend"; end
                2: begin exp_v = 7'b0; tag = "R6_clk_start"; end
                3: begin exp_v = 7'b0010000; tag = "R7_osc_wait"; end
                4: begin exp_v = {1'b0, !m_ext, m_ext, 4'b0}; tag = "R8_delay"; end
                default: begin exp_v = {1'b1, !m_ext, m_ext, 1'b0, 1'b0, 1'b1, 1'b1}; tag = "R9_release"; end
            endcase
            act_v = {core_clk_en, int_clk_en, ext_osc_en, tmr_clk_en, wdt_clk_en, core_run, irq_hold};
            check(tag, int'(act_v), int'(exp_v));
        end
    end

    task automatic enter(input bit run, input bit ext, input bit lng);
        @(negedge clk);
        cfg_wr = 1; cfg_suspend = 1; cfg_run = run; ext_clk_sel = ext; long_delay_sel = lng;
        @(negedge clk);
        cfg_wr = 0;
        check("R2 suspend gates core", int'(core_clk_en), 0);
    endtask

    task automatic measure(input string tag, input int exp_n);
        int n = 0;
        do begin @(negedge clk); n++; end while (!irq_hold && n < T_LONG + 100);
        check(tag, n, exp_n);
        check("R10 timers off in release", int'(tmr_clk_en), 0);
        @(negedge clk);
        check("R9 hold lasts one cycle", int'(irq_hold), 0);
        check("R9 back in run", int'(core_run && tmr_clk_en && wdt_clk_en), 1);
    endtask

    task automatic clear_wake();
        gpio_pend = 0; gpio_en = 0; wkt_pend = 0; wkt_en = 0;
        spi_pend = 0; spi_en = 0; dminus_in = 1; osc_stable = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check("R1 reset run", int'({core_clk_en, int_clk_en, tmr_clk_en, wdt_clk_en, core_run}), 31);
        check("R1 reset hold", int'(irq_hold), 0);

        cfg_wr = 1; cfg_suspend = 0; cfg_run = 1;
        @(negedge clk);
        cfg_wr = 0;
        check("R2 write without suspend ignored", int'(core_run), 1);

        // Internal path, GPIO wake
        enter(1, 0, 0);
        repeat (5) @(negedge clk);
        check("R2 stays suspended", int'(core_run), 0);
        gpio_pend = 1; gpio_en = 1;
        measure("R6 internal latency", T_START + T_INT + 1);
        clear_wake();

        // Pending but disabled sources, then SPI wake
        enter(1, 0, 0);
        spi_pend = 1; wkt_pend = 1; gpio_pend = 1;
        repeat (10) @(negedge clk);
        check("R3 disabled sources ignored", int'(core_run), 0);
        spi_en = 1;
        measure("R3 spi wake latency", T_START + T_INT + 1);
        clear_wake();

        enter(1, 0, 0);
        wkt_pend = 1; wkt_en = 1;
        measure("R3 timer wake latency", T_START + T_INT + 1);
        clear_wake();

        enter(1, 0, 0);
        dminus_in = 0;
        measure("R3 dminus wake latency", T_START + T_INT + 3);
        clear_wake();
        repeat (3) @(negedge clk);

        // Wake already present at entry
        gpio_pend = 1; gpio_en = 1;
        @(negedge clk);
        cfg_wr = 1; cfg_suspend = 1; cfg_run = 1; ext_clk_sel = 0; long_delay_sel = 0;
        @(negedge clk);
        cfg_wr = 0;
        check("R4 suspended despite wake", int'(core_clk_en || core_run), 0);
        measure("R4 full delay after entry", T_START + T_INT + 1);
        clear_wake();

        // External path, short delay
        enter(1, 1, 0);
        gpio_pend = 1; gpio_en = 1;
        repeat (20) @(negedge clk);
        check("R7 oscillator on while unstable", int'(ext_osc_en), 1);
        check("R7 core held while unstable", int'(core_run || int_clk_en), 0);
        osc_stable = 1;
        measure("R8 short delay", T_SHORT + 1);
        clear_wake();

        // External path, long delay; mode inputs change during suspend
        enter(1, 1, 1);
        ext_clk_sel = 0; long_delay_sel = 0;
        repeat (3) @(negedge clk);
        gpio_pend = 1; gpio_en = 1;
        repeat (3) @(negedge clk);
        check("R11 captured external path", int'(ext_osc_en), 1);
        osc_stable = 1;
        measure("R8 R11 long delay", T_LONG + 1);
        clear_wake();

        // No run bit: never resumes
        enter(0, 0, 0);
        gpio_pend = 1; gpio_en = 1; spi_pend = 1; spi_en = 1; dminus_in = 0;
        repeat (50) @(negedge clk);
        check("R5 no resume without run", int'(core_run || core_clk_en), 0);
        clear_wake();
        rst_n = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check("R1 reset recovers run", int'(core_run && tmr_clk_en), 1);

        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule